// File: doc/BRIEF.md
# Program Status Word and Interrupt Entry Unit

This block holds the program status word of a small processor and carries out the hardware half of interrupt entry and return. The status word carries the program counter, a privilege bit, a base and a size that bound the memory a user program may touch, one enable bit per external interrupt source and an interrupt cause code. The unit watches the processor's data accesses and privileged operations. Each cycle it decides whether an interrupt must be taken. When one is taken, it swaps the whole status word for one taken from a per-class vector table.

On entry, the outgoing status word is stamped with the cause code and then presented on a save bus with a one-cycle write strobe. Kernel software can store it in a save area from there. A return strobe, allowed only in kernel mode, reloads a complete saved status word. The same return is how a program is first started in user mode with its memory window and interrupt enables. Program-raised causes (out-of-window access, privileged operation in user mode, software interrupt) cannot be masked. External sources obey their enable bits.

Top module: `psw_entry_ctrl`

## Requirements
- R1: After reset `psw_o` is all zeros (kernel mode, PC 0, all external sources disabled) and `save_we_o` is 0. The word is packed, from MSB to LSB, as {pc[15:0], mode, base[15:0], size[15:0], im[1:0], ic[7:0]}. mode = 0 means kernel and mode = 1 means user.
- R2: In user mode, a data access (`addr_valid_i` = 1) is legal when base <= addr <= base + size − 1, using unbounded arithmetic. Any other access drives `prot_viol_o` high in the same cycle and raises a protection interrupt with cause code 8'hFF. A window of size 0 rejects every address. In kernel mode no access is checked.
- R3: In user mode, `priv_i` or `rti_i` raises a privilege interrupt with cause code 8'hFE. The return is not carried out.
- R4: A software interrupt (`swi_i`) is taken in either mode, and its cause code is `swi_code_i`.
- R5: On entry, `save_we_o` is high for exactly the cycle after the triggering edge. In that cycle `save_psw_o` equals the old status word with its ic field replaced by the cause code. From the same edge, `psw_o` equals vector entry c (bits [c*59 +: 59] of `vec_psw_i`) with mode forced to 0 and im forced to 0. The class c is 0 for protection, 1 for privilege, 2 for software and 3+k for external source k.
- R6: When several causes are present at once, priority runs protection, then privilege, then software interrupt, then external sources.
- R7: External source k is taken only when `ext_req_i[k]` and im bit k are both 1. Among enabled sources the lowest index wins, and its cause code is k.
- R8: In kernel mode, with no interrupt being taken, `rti_i` loads `rti_psw_i` into `psw_o` in full on the next edge, with no save strobe. A simultaneous interrupt takes precedence over the return.
- R9: In kernel mode `priv_i` has no effect on `psw_o` or `save_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_i | input | 2 | External interrupt requests, one per source |
| swi_i | input | 1 | Software interrupt strobe |
| swi_code_i | input | 8 | Software interrupt code |
| priv_i | input | 1 | Privileged operation attempted |
| addr_valid_i | input | 1 | Data access under way |
| addr_i | input | 16 | Data access address |
| rti_i | input | 1 | Return-from-interrupt strobe |
| rti_psw_i | input | 59 | Status word to reload on return |
| vec_psw_i | input | 295 | Vector status words, five classes of 59 bits |
| psw_o | output | 59 | Current status word |
| save_we_o | output | 1 | Save area write strobe |
| save_psw_o | output | 59 | Status word to save |
| prot_viol_o | output | 1 | Protection violation in this cycle |

## Verification
The hardest situation to reach is a cycle in user mode where several causes compete, or where a window edge or an empty window decides the outcome. Every entry drops the unit into kernel mode with all sources masked, so the bench first has to climb back out with a kernel-mode return carrying a chosen user window and enable pattern. Only then does it fire the simultaneous or boundary stimulus. A behavioural reference model tracks the expected status word across each entry and return and compares every cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;
  parameter int PC_W = 16;
  parameter int AW   = 16;
  parameter int NEXT = 2;
  parameter int CW   = 8;

  localparam int PSW_W    = PC_W + 1 + 2 * AW + NEXT + CW;
  localparam int NCLS     = 3 + NEXT;
  localparam int CLS_W    = $clog2(NCLS);
  localparam int MODE_BIT = PSW_W - PC_W - 1;

  localparam int CLS_PROT = 0;
  localparam int CLS_PRIV = 1;
  localparam int CLS_SWI  = 2;
  localparam int CLS_EXT0 = 3;

  localparam logic [CW-1:0] IC_PROT = {CW{1'b1}};
  localparam logic [CW-1:0] IC_PRIV = {{(CW-1){1'b1}}, 1'b0};

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic            mode;
    logic [AW-1:0]   base;
    logic [AW-1:0]   size;
    logic [NEXT-1:0] im;
    logic [CW-1:0]   ic;
  } psw_t;
endpackage

// File: rtl/psw_guard.sv
module psw_guard
  import psw_pkg::*;
(
  input  logic          user_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  input  logic          addr_valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          priv_i,
  input  logic          rti_i,
  output logic          prot_viol_o,
  output logic          priv_viol_o
);
  logic [AW:0] limit;
  logic        below;
  logic        above;

  always_comb begin
    limit       = {1'b0, base_i} + {1'b0, size_i};
    below       = {1'b0, addr_i} < {1'b0, base_i};
    above       = {1'b0, addr_i} >= limit;
    prot_viol_o = user_i && addr_valid_i && (below || above);
    priv_viol_o = user_i && (priv_i || rti_i);
  end
endmodule

// File: rtl/psw_arbiter.sv
module psw_arbiter
  import psw_pkg::*;
(
  input  logic             prot_i,
  input  logic             priv_i,
  input  logic             swi_i,
  input  logic [CW-1:0]    swi_code_i,
  input  logic [NEXT-1:0]  ext_req_i,
  input  logic [NEXT-1:0]  im_i,
  output logic             take_o,
  output logic [CLS_W-1:0] cls_o,
  output logic [CW-1:0]    code_o
);
  always_comb begin
    take_o = 1'b0;
    cls_o  = '0;
    code_o = '0;
    for (int k = NEXT - 1; k >= 0; k--) begin
      if (ext_req_i[k] && im_i[k]) begin
        take_o = 1'b1;
        cls_o  = CLS_W'(CLS_EXT0 + k);
        code_o = CW'(k);
      end
    end
    if (swi_i) begin
      take_o = 1'b1;
      cls_o  = CLS_W'(CLS_SWI);
      code_o = swi_code_i;
    end
    if (priv_i) begin
      take_o = 1'b1;
      cls_o  = CLS_W'(CLS_PRIV);
      code_o = IC_PRIV;
    end
    if (prot_i) begin
      take_o = 1'b1;
      cls_o  = CLS_W'(CLS_PROT);
      code_o = IC_PROT;
    end
  end
endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import psw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take_i,
  input  logic [CLS_W-1:0]      cls_i,
  input  logic [CW-1:0]         code_i,
  input  logic                  rti_ok_i,
  input  logic [PSW_W-1:0]      rti_psw_i,
  input  logic [NCLS*PSW_W-1:0] vec_psw_i,
  output psw_t                  psw_o,
  output logic                  save_we_o,
  output psw_t                  save_psw_o
);
  psw_t vec_arr [NCLS];
  psw_t psw_q, psw_d;
  psw_t save_q, save_d;
  logic we_q, we_d;
  psw_t vec_sel;

  for (genvar c = 0; c < NCLS; c++) begin : g_vec
    assign vec_arr[c] = psw_t'(vec_psw_i[c*PSW_W +: PSW_W]);
  end

  always_comb begin
    vec_sel = vec_arr[0];
    for (int c = 0; c < NCLS; c++) begin
      if (int'(cls_i) == c) vec_sel = vec_arr[c];
    end
  end

  always_comb begin
    psw_d  = psw_q;
    save_d = save_q;
    we_d   = 1'b0;
    if (take_i) begin
      save_d      = psw_q;
      save_d.ic   = code_i;
      psw_d       = vec_sel;
      psw_d.mode  = 1'b0;
      psw_d.im    = '0;
      we_d        = 1'b1;
    end else if (rti_ok_i) begin
      psw_d = psw_t'(rti_psw_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q  <= '0;
      save_q <= '0;
      we_q   <= 1'b0;
    end else begin
      psw_q <= psw_d;
      we_q  <= we_d;
      if (take_i) save_q <= save_d;
    end
  end

  assign psw_o      = psw_q;
  assign save_we_o  = we_q;
  assign save_psw_o = save_q;
endmodule

// File: rtl/psw_entry_ctrl.sv
module psw_entry_ctrl
  import psw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NEXT-1:0]       ext_req_i,
  input  logic                  swi_i,
  input  logic [CW-1:0]         swi_code_i,
  input  logic                  priv_i,
  input  logic                  addr_valid_i,
  input  logic [AW-1:0]         addr_i,
  input  logic                  rti_i,
  input  logic [PSW_W-1:0]      rti_psw_i,
  input  logic [NCLS*PSW_W-1:0] vec_psw_i,
  output logic [PSW_W-1:0]      psw_o,
  output logic                  save_we_o,
  output logic [PSW_W-1:0]      save_psw_o,
  output logic                  prot_viol_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  psw_t             cur;
  psw_t             saved;
  logic             prot_viol;
  logic             priv_viol;
  logic             take;
  logic [CLS_W-1:0] cls;
  logic [CW-1:0]    code;
  logic             rti_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  psw_guard u_guard (
    .user_i       (cur.mode),
    .base_i       (cur.base),
    .size_i       (cur.size),
    .addr_valid_i (addr_valid_i),
    .addr_i       (addr_i),
    .priv_i       (priv_i),
    .rti_i        (rti_i),
    .prot_viol_o  (prot_viol),
    .priv_viol_o  (priv_viol)
  );

  psw_arbiter u_arb (
    .prot_i     (prot_viol),
    .priv_i     (priv_viol),
    .swi_i      (swi_i),
    .swi_code_i (swi_code_i),
    .ext_req_i  (ext_req_i),
    .im_i       (cur.im),
    .take_o     (take),
    .cls_o      (cls),
    .code_o     (code)
  );

  assign rti_ok = rti_i && !cur.mode;

  psw_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .take_i     (take),
    .cls_i      (cls),
    .code_i     (code),
    .rti_ok_i   (rti_ok),
    .rti_psw_i  (rti_psw_i),
    .vec_psw_i  (vec_psw_i),
    .psw_o      (cur),
    .save_we_o  (save_we_o),
    .save_psw_o (saved)
  );

  assign psw_o       = cur;
  assign save_psw_o  = saved;
  assign prot_viol_o = prot_viol;
endmodule

// File: rtl/psw_entry_ctrl_chk.sv
module psw_entry_ctrl_chk
  import psw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             swi_i,
  input logic [CW-1:0]    swi_code_i,
  input logic             priv_i,
  input logic             rti_i,
  input logic [PSW_W-1:0] psw_o,
  input logic             save_we_o,
  input logic [PSW_W-1:0] save_psw_o,
  input logic             prot_viol_o
);
  logic            mode;
  logic [NEXT-1:0] im;
  assign mode = psw_o[MODE_BIT];
  assign im   = psw_o[CW +: NEXT];

  AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    save_we_o |-> (!mode && im == '0)); // R5

  AST_SAVE_IS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    save_we_o |-> (save_psw_o[PSW_W-1:CW] == $past(psw_o[PSW_W-1:CW]))); // R5

  AST_PROT_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    prot_viol_o |-> mode); // R2

  AST_PRIV_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && priv_i) |=> save_we_o); // R3

  AST_SWI_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_i && !mode) |=> (save_we_o && save_psw_o[CW-1:0] == $past(swi_code_i))); // R4

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && im == '0 && !swi_i) |=> !save_we_o); // R7

  AST_KERNEL_PRIV_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && priv_i && !swi_i && !rti_i && im == '0) |=> $stable(psw_o)); // R9
endmodule

bind psw_entry_ctrl psw_entry_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .swi_i       (swi_i),
  .swi_code_i  (swi_code_i),
  .priv_i      (priv_i),
  .rti_i       (rti_i),
  .psw_o       (psw_o),
  .save_we_o   (save_we_o),
  .save_psw_o  (save_psw_o),
  .prot_viol_o (prot_viol_o)
);

// File: tb/psw_entry_ctrl_tb_top.sv
module psw_entry_ctrl_tb_top;
  import psw_pkg::*;

  logic                  clk;
  logic                  rst_n;
  logic [NEXT-1:0]       ext_req;
  logic                  swi;
  logic [CW-1:0]         swi_code;
  logic                  priv;
  logic                  addr_valid;
  logic [AW-1:0]         addr;
  logic                  rti;
  logic [PSW_W-1:0]      rti_psw;
  logic [NCLS*PSW_W-1:0] vec;
  logic [PSW_W-1:0]      psw;
  logic                  save_we;
  logic [PSW_W-1:0]      save_psw;
  logic                  prot_viol;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  psw_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_req_i(ext_req), .swi_i(swi), .swi_code_i(swi_code),
    .priv_i(priv), .addr_valid_i(addr_valid), .addr_i(addr), .rti_i(rti),
    .rti_psw_i(rti_psw), .vec_psw_i(vec), .psw_o(psw), .save_we_o(save_we),
    .save_psw_o(save_psw), .prot_viol_o(prot_viol)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [PSW_W-1:0] mk(input int pc, input bit m, input int b,
                                          input int s, input int im, input int ic);
    return {PC_W'(pc), m, AW'(b), AW'(s), NEXT'(im), CW'(ic)};
  endfunction

  // Behavioural reference model
  logic [PSW_W-1:0] m_psw;
  logic [PSW_W-1:0] m_save;
  bit               m_we;
  int               rel_cnt;

  function automatic bit m_viol(input logic [PSW_W-1:0] p, input bit v, input int a);
    int lo, hi;
    lo = int'(p[CW+NEXT+AW +: AW]);
    hi = lo + int'(p[CW+NEXT +: AW]);
    return v && p[MODE_BIT] && (a < lo || a >= hi);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_psw = '0; m_we = 0; m_save = '0; rel_cnt = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      int cls;
      logic [CW-1:0] code;
      bit user;
      user = m_psw[MODE_BIT];
      cls  = -1;
      code = '0;
      if (m_viol(m_psw, addr_valid, int'(addr))) begin cls = 0; code = 8'hFF; end
      else if (user && (priv || rti))          begin cls = 1; code = 8'hFE; end
      else if (swi)                            begin cls = 2; code = swi_code; end
      else begin
        for (int k = 0; k < NEXT; k++)
          if (ext_req[k] && m_psw[CW+k]) begin cls = 3 + k; code = CW'(k); break; end
      end
      m_we = 0;
      if (cls >= 0) begin
        m_save = {m_psw[PSW_W-1:CW], code};
        m_psw  = vec[cls*PSW_W +: PSW_W];
        m_psw[MODE_BIT] = 1'b0;
        m_psw[CW +: NEXT] = '0;
        m_we = 1;
      end else if (rti && !user) begin
        m_psw = rti_psw;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = m_viol(m_psw, addr_valid, int'(addr));
      n_checks++;
      if (psw !== m_psw || save_we !== m_we || prot_viol !== ev ||
          (m_we && save_psw !== m_save)) begin
        n_fail++;
        $display("FAIL %s: psw=%h save_we=%b save=%h viol=%b expected psw=%h save_we=%b save=%h viol=%b",
                 cur_req, psw, save_we, save_psw, prot_viol, m_psw, m_we, m_save, ev);
      end
    end
  end

  task automatic idle();
    ext_req = '0; swi = 0; swi_code = '0; priv = 0; addr_valid = 0; addr = '0; rti = 0;
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      idle();
    end
  endtask

  task automatic resume(input logic [PSW_W-1:0] p);
    rti_psw = p; rti = 1; step(2);
  endtask

  initial begin
    for (int c = 0; c < NCLS; c++)
      vec[c*PSW_W +: PSW_W] = mk(16'h8000 + c * 16'h10, 1, 0, 16'hFFFF, 3, 0);
    idle();
    rti_psw = '0;
    rst_n = 0;
    #23 rst_n = 1;
    cur_req = "R1"; // reset state
    step(4);

    cur_req = "R8"; // kernel return starts user program
    resume(mk(16'h0100, 1, 16'h1000, 16'h0100, 3, 0));

    cur_req = "R2"; // inside window, both edges
    addr_valid = 1; addr = 16'h1000; step();
    addr_valid = 1; addr = 16'h10FF; step();
    addr_valid = 1; addr = 16'h1100; step(2);   // one past top
    resume(mk(16'h0100, 1, 16'h1000, 16'h0100, 3, 0));
    addr_valid = 1; addr = 16'h0FFF; step(2);   // one below base
    resume(mk(16'h0200, 1, 16'h2000, 16'h0000, 3, 0));
    addr_valid = 1; addr = 16'h2000; step(2);   // empty window
    resume(mk(16'h0300, 1, 16'hFF00, 16'h0100, 3, 0));
    addr_valid = 1; addr = 16'hFFFF; step(2);   // window ends at top of space

    cur_req = "R3";
    resume(mk(16'h0100, 1, 16'h1000, 16'h0100, 3, 0));
    priv = 1; step(2);
    resume(mk(16'h0100, 1, 16'h1000, 16'h0100, 3, 0));
    rti = 1; rti_psw = mk(16'h0DEAD, 0, 0, 0, 0, 0); step(2);

    cur_req = "R4";
    resume(mk(16'h0140, 1, 16'h1000, 16'h0100, 3, 0));
    swi = 1; swi_code = 8'h4E; step(2);
    swi = 1; swi_code = 8'h11; step(2);          // from kernel mode

    cur_req = "R6";
    resume(mk(16'h0100, 1, 16'h1000, 16'h0100, 3, 0));
    addr_valid = 1; addr = 16'h3000; priv = 1; swi = 1; swi_code = 8'h22; ext_req = 2'b11; step(2);
    resume(mk(16'h0100, 1, 16'h1000, 16'h0100, 3, 0));
    priv = 1; swi = 1; swi_code = 8'h23; ext_req = 2'b11; step(2);
    resume(mk(16'h0100, 1, 16'h1000, 16'h0100, 3, 0));
    swi = 1; swi_code = 8'h24; ext_req = 2'b11; step(2);

    cur_req = "R7";
    resume(mk(16'h0100, 1, 16'h1000, 16'h0100, 1, 0));
    ext_req = 2'b10; step(2);                    // masked source ignored
    ext_req = 2'b11; step(2);
    resume(mk(16'h0100, 1, 16'h1000, 16'h0100, 2, 0));
    ext_req = 2'b11; step(2);
    resume(mk(16'h0100, 1, 16'h1000, 16'h0100, 3, 0));
    ext_req = 2'b11; step(2);
    ext_req = 2'b11; step(2);                    // kernel, masked after entry

    cur_req = "R9";
    priv = 1; step(2);
    addr_valid = 1; addr = 16'hFFFF; step(2);     // kernel access unchecked

    cur_req = "R8";
    rti = 1; rti_psw = mk(16'h0500, 0, 16'h0010, 16'h0020, 3, 8'h5A); swi = 1; swi_code = 8'h33; step(2);
    rti = 1; rti_psw = mk(16'h0600, 1, 16'h4000, 16'h1000, 2, 8'hA5); step(2);
    ext_req = 2'b10; step(2);

    cur_req = "R1"; // reset in mid-run returns to zero state
    rst_n = 0; #10 rst_n = 1;
    step(5);

    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule